// File: doc/BRIEF.md
# Erasable Byte Memory Emulator with Mode Decode

This block is a synthesizable stand-in for a byte-wide, electrically programmed, light-erased memory. Host controllers and programmer state machines can be tested against it. Three control inputs decide the operating mode on every clock: an active-low chip select, an active-low output gate and a flag that says the programming supply is present. The block decodes them into one of seven modes. It serves reads with a configurable settling delay, accepts program pulses and lets the stored word be read back in a verify mode.

Programming follows the physics of a floating-gate cell. A pulse can only turn ones into zeros, so the stored word becomes the old word AND the presented data. Only the erase input brings bits back to one. A counter of completed program pulses is exposed, so a bench can confirm how many pulses a controller issued. The data output models a tristate bus: a drive-enable flag, and a zero value whenever the bus is not driven. The default depth is 2^11 words. Setting `ADDR_W` to 15 gives the full 32K-word part.

Top module: `eprom_emu`

## Requirements
- R1: After reset every address reads 8'hFF, `mode` is 0 (standby), `dout_oe` and `dout_valid` are low and `pulse_cnt` is 0.
- R2: One clock edge after the inputs are sampled, `mode` reports their decode as {vpp_hi,ce_n,oe_n}: 000 read=1, 001 output-off=2, 01x standby=0, 101 program=3, 110 verify=4, 111 inhibit=5, 100 conflict=6.
- R3: In every mode other than read (1) and verify (4), `dout_oe` is low and `dout` is zero.
- R4: `dout_valid` rises at the (SETTLE_CYC+1)-th consecutive clock edge at which the mode stays read or verify and `addr` is unchanged. A change of address or mode drops it at the next edge.
- R5: A program pulse is finished by the first edge that sees program mode (3) turn into inhibit mode (5), which is the rising edge of `ce_n`. That edge writes old AND `din` to `addr`, using the values present at that edge.
- R6: Programming never sets a bit. A second pulse with different data leaves the AND of both data words, and a pulse with 8'hFF leaves the word unchanged.
- R7: A cycle with `erase` high returns every word to 8'hFF. If a program pulse finishes in the same cycle, its write is discarded.
- R8: Inhibit mode, with any `addr` and `din`, alters no stored word and no pulse count.
- R9: In verify mode, once `dout_valid` is high, `dout` carries the stored word at the sampled address, and it stays stable while `dout_valid` stays high and no erase occurs.
- R10: `pulse_cnt` adds one for each finished program pulse, erase or not, and wraps modulo 2^PCNT_W.
- R11: Conflict mode (supply present, both enables low) drives nothing. Leaving it with `ce_n` rising writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low; its low pulse programs |
| oe_n | input | 1 | Output gate, active low |
| vpp_hi | input | 1 | Programming supply present |
| erase | input | 1 | Return all words to ones |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Data for a program pulse |
| dout | output | DATA_W | Read or verify data, zero when not valid |
| dout_oe | output | 1 | Bus drive enable |
| dout_valid | output | 1 | Data settled and valid |
| mode | output | 3 | Registered mode code (see R2) |
| pulse_cnt | output | PCNT_W | Finished program pulses, wrapping |

## Verification
The assertions assume that `SETTLE_CYC` is at least one. They also assume that only a program pulse or an erase ever changes a stored word, so any change to a valid output must come from a change of address or mode. The stimulus drives every input at the falling clock edge, well away from the sampling edge. It holds each random input set for one to six cycles, so reads can mature to valid. It also keeps addresses in a small window, so that programs, verifies and erases hit the same words.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY  = 3'd0,
    MODE_READ     = 3'd1,
    MODE_OUTOFF   = 3'd2,
    MODE_PROGRAM  = 3'd3,
    MODE_VERIFY   = 3'd4,
    MODE_INHIBIT  = 3'd5,
    MODE_CONFLICT = 3'd6
  } emu_mode_e;

  function automatic logic mode_drives(emu_mode_e m);
    return (m == MODE_READ) || (m == MODE_VERIFY);
  endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_emu_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp_hi,
  output emu_mode_e mode
);

  always_comb begin
    mode = MODE_STANDBY;
    case ({vpp_hi, ce_n, oe_n})
      3'b000: mode = MODE_READ;
      3'b001: mode = MODE_OUTOFF;
      3'b010: mode = MODE_STANDBY;
      3'b011: mode = MODE_STANDBY;
      3'b100: mode = MODE_CONFLICT;
      3'b101: mode = MODE_PROGRAM;
      3'b110: mode = MODE_VERIFY;
      3'b111: mode = MODE_INHIBIT;
      default: mode = MODE_STANDBY;
    endcase
  end

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  // A word whose flag is clear reads as all ones, so erase clears flags only
  logic [DEPTH-1:0]  touched_q;
  logic [DEPTH-1:0]  touched_d;
  logic              touched_en;
  logic [DATA_W-1:0] cells_q [DEPTH];
  logic [DATA_W-1:0] old_word;
  logic              cell_we;

  assign old_word   = touched_q[wr_addr] ? cells_q[wr_addr] : '1;
  assign cell_we    = wr_en && !erase;
  assign touched_en = erase || wr_en;

  always_comb begin
    touched_d = touched_q;
    if (erase) begin
      touched_d = '0;
    end else if (wr_en) begin
      touched_d[wr_addr] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      touched_q <= '0;
    end else if (touched_en) begin
      touched_q <= touched_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cell_we) begin
      cells_q[wr_addr] <= old_word & wr_data;
    end
  end

  assign rd_data = touched_q[rd_addr] ? cells_q[rd_addr] : '1;

endmodule

// File: rtl/eprom_settle_timer.sv
module eprom_settle_timer #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_next,
  input  logic restart,
  output logic ready
);

  localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!drive_next || restart) begin
      cnt_d = '0;
    end else if (cnt_q != LAST) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign ready = (cnt_q == LAST);

endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
  import eprom_emu_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 3,
  parameter int PCNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              dout_valid,
  output logic [2:0]        mode,
  output logic [PCNT_W-1:0] pulse_cnt
);

  // reset: asynchronous assert, two-flop synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  emu_mode_e         mode_d;
  emu_mode_e         mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PCNT_W-1:0] pulse_q;
  logic [PCNT_W-1:0] pulse_d;
  logic              pulse_done;
  logic              restart;
  logic              ready;
  logic              drive;
  logic [DATA_W-1:0] rd_word;

  eprom_mode_decode u_decode (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .mode   (mode_d)
  );

  assign pulse_done = (mode_q == MODE_PROGRAM) && (mode_d == MODE_INHIBIT);
  assign restart    = (mode_d != mode_q) || (addr != addr_q);

  always_comb begin
    pulse_d = pulse_q;
    if (pulse_done) begin
      pulse_d = pulse_q + PCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q  <= MODE_STANDBY;
      addr_q  <= '0;
      pulse_q <= '0;
    end else begin
      mode_q  <= mode_d;
      addr_q  <= addr;
      pulse_q <= pulse_d;
    end
  end

  eprom_cell_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cells (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .erase   (erase),
    .wr_en   (pulse_done),
    .wr_addr (addr),
    .wr_data (din),
    .rd_addr (addr_q),
    .rd_data (rd_word)
  );

  eprom_settle_timer #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .drive_next (mode_drives(mode_d)),
    .restart    (restart),
    .ready      (ready)
  );

  assign drive      = mode_drives(mode_q);
  assign dout_oe    = drive;
  assign dout_valid = drive && ready;
  assign dout       = dout_valid ? rd_word : '0;
  assign mode       = mode_q;
  assign pulse_cnt  = pulse_q;

endmodule

// File: rtl/eprom_emu_checker.sv
module eprom_emu_checker #(
  parameter int DATA_W = 8,
  parameter int PCNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              erase,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe,
  input logic              dout_valid,
  input logic [2:0]        mode,
  input logic [PCNT_W-1:0] pulse_cnt
);

  assert_mode_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 3'd7);

  assert_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode == 3'd1 || mode == 3'd4) |-> (!dout_oe && dout == '0));

  assert_valid_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> dout_oe);

  assert_valid_after_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_valid) |-> $past(dout_oe));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && $past(dout_valid) && !$past(erase)) |-> $stable(dout));

  assert_pulse_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt != $past(pulse_cnt)) |->
      (pulse_cnt == $past(pulse_cnt) + PCNT_W'(1)) && ($past(mode) == 3'd3) && (mode == 3'd5));

endmodule

bind eprom_emu eprom_emu_checker #(
  .DATA_W (DATA_W),
  .PCNT_W (PCNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .erase      (erase),
  .dout       (dout),
  .dout_oe    (dout_oe),
  .dout_valid (dout_valid),
  .mode       (mode),
  .pulse_cnt  (pulse_cnt)
);

// File: tb/eprom_emu_tb_top.sv
module eprom_emu_tb_top;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int D  = 3;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          vpp_hi = 1'b0;
  logic          erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;
  logic          dout_valid;
  logic [2:0]    mode;
  logic [PW-1:0] pulse_cnt;

  int checks = 0;
  int failures = 0;
  bit model_on = 0;
  bit finished = 0;

  // 8 time units per period: 125 MHz with 1 ns units
  always #4 clk = ~clk;

  eprom_emu #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(D), .PCNT_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .erase(erase), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .dout_valid(dout_valid), .mode(mode), .pulse_cnt(pulse_cnt)
  );

  // ---------------- behavioural reference ----------------
  int unsigned mem_m[int];
  int m_mode, m_addr, m_settle, m_cnt;

  function automatic int decode(bit v, bit c, bit o);
    if (!v) return c ? 0 : (o ? 2 : 1);
    if (!c) return o ? 3 : 6;
    return o ? 5 : 4;
  endfunction

  function automatic int word_m(int a);
    return mem_m.exists(a) ? int'(mem_m[a]) : 255;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_m.delete();
      m_mode = 0; m_addr = 0; m_settle = 0; m_cnt = 0;
    end else begin
      int nm;
      bit rs;
      nm = decode(vpp_hi, ce_n, oe_n);
      rs = (nm != m_mode) || (int'(addr) != m_addr);
      if (m_mode == 3 && nm == 5) begin
        m_cnt = (m_cnt + 1) % (1 << PW);
        if (!erase) mem_m[int'(addr)] = word_m(int'(addr)) & int'(din);
      end
      if (erase) mem_m.delete();
      if (!(nm == 1 || nm == 4) || rs) m_settle = 0;
      else if (m_settle < D) m_settle = m_settle + 1;
      m_mode = nm;
      m_addr = int'(addr);
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      int e_oe, e_val, e_dout;
      e_oe   = (m_mode == 1 || m_mode == 4) ? 1 : 0;
      e_val  = (e_oe == 1 && m_settle == D) ? 1 : 0;
      e_dout = e_val ? word_m(m_addr) : 0;
      check(int'(mode) == m_mode, "R2 mode", int'(mode), m_mode);
      check(int'(dout_oe) == e_oe, "R3 dout_oe", int'(dout_oe), e_oe);
      check(int'(dout_valid) == e_val, "R4 dout_valid", int'(dout_valid), e_val);
      check(int'(dout) == e_dout, "R9 dout", int'(dout), e_dout);
      check(int'(pulse_cnt) == m_cnt, "R10 pulse_cnt", int'(pulse_cnt), m_cnt);
    end
  end

  // ---------------- directed helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctl(bit v, bit c, bit o);
    vpp_hi = v; ce_n = c; oe_n = o;
  endtask

  task automatic program_word(int a, int d);
    set_ctl(1, 1, 1); cyc(1);
    addr = AW'(a); din = DW'(d);
    set_ctl(1, 0, 1); cyc(2);
    set_ctl(1, 1, 1); cyc(1);
  endtask

  task automatic look(bit verify, int a, int exp, string req);
    addr = AW'(a);
    if (verify) set_ctl(1, 1, 0); else set_ctl(0, 0, 0);
    cyc(D + 2);
    check(dout_valid == 1'b1 && int'(dout) == exp, req, int'(dout), exp);
    set_ctl(0, 1, 1); cyc(1);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int npulse;
    npulse = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    model_on = 1;
    cyc(4);
    // R1 reset state
    check(mode == 3'd0 && !dout_oe && !dout_valid && pulse_cnt == '0, "R1 reset state",
          int'(mode), 0);
    look(0, 0, 8'hFF, "R1 read fresh low");
    look(0, (1 << AW) - 1, 8'hFF, "R1 read fresh top");

    // R2 every decode code
    for (int k = 0; k < 8; k++) begin
      set_ctl(k[2], k[1], k[0]);
      cyc(1);
      check(int'(mode) == decode(k[2], k[1], k[0]), "R2 decode", int'(mode),
            decode(k[2], k[1], k[0]));
      check(!(mode != 3'd1 && mode != 3'd4 && dout_oe), "R3 float", int'(dout_oe), 0);
    end
    set_ctl(0, 1, 1); cyc(2);

    // R5 / R9 program then verify
    program_word(5, 8'hA5); npulse++;
    look(1, 5, 8'hA5, "R5 R9 verify after program");
    look(0, 5, 8'hA5, "R5 read after program");

    // R6 bits only clear
    program_word(5, 8'h3C); npulse++;
    look(1, 5, 8'h24, "R6 and of data");
    program_word(5, 8'hFF); npulse++;
    look(1, 5, 8'h24, "R6 ones do not set");

    // R4 address change drops valid
    addr = 5; set_ctl(0, 0, 0); cyc(D + 2);
    check(dout_valid == 1'b1, "R4 valid settled", int'(dout_valid), 1);
    addr = 6; cyc(1);
    check(dout_valid == 1'b0, "R4 valid drops on address change", int'(dout_valid), 0);
    cyc(D - 1);
    check(dout_valid == 1'b0, "R4 not yet valid", int'(dout_valid), 0);
    cyc(1);
    check(dout_valid == 1'b1 && dout == 8'hFF, "R4 valid after delay", int'(dout), 8'hFF);
    set_ctl(0, 1, 1); cyc(1);

    // R8 inhibit ignores data
    set_ctl(1, 1, 1);
    for (int k = 0; k < 6; k++) begin
      addr = AW'(7 + k); din = DW'(k); cyc(1);
    end
    check(int'(pulse_cnt) == npulse % (1 << PW), "R8 no pulse in inhibit", int'(pulse_cnt), npulse);
    look(1, 7, 8'hFF, "R8 word untouched by inhibit");

    // R11 conflict mode then ce rises: no write, no drive
    addr = 9; din = 8'h00; set_ctl(1, 0, 0); cyc(2);
    check(dout_oe == 1'b0 && dout == '0, "R11 conflict floats", int'(dout_oe), 0);
    set_ctl(1, 1, 0); cyc(1);
    look(1, 9, 8'hFF, "R11 conflict wrote nothing");

    // R7 erase restores ones, wins over a finishing pulse
    erase = 1'b1; cyc(1); erase = 1'b0;
    look(1, 5, 8'hFF, "R7 erase restores");
    set_ctl(1, 1, 1); cyc(1);
    addr = 3; din = 8'h0F; set_ctl(1, 0, 1); cyc(2);
    set_ctl(1, 1, 1); erase = 1'b1; cyc(1); erase = 1'b0; npulse++;
    look(1, 3, 8'hFF, "R7 erase beats write");

    // R10 counter wraps
    for (int k = 0; k < 14; k++) begin
      program_word(20, 8'hF0); npulse++;
    end
    check(int'(pulse_cnt) == npulse % (1 << PW), "R10 wrap", int'(pulse_cnt), npulse % (1 << PW));

    // random traffic against the reference
    for (int k = 0; k < 1500; k++) begin
      vpp_hi = 1'($urandom_range(1));
      ce_n   = 1'($urandom_range(1));
      oe_n   = 1'($urandom_range(1));
      addr   = AW'($urandom_range(7));
      din    = DW'($urandom);
      erase  = ($urandom_range(99) == 0);
      cyc(1);
      erase  = 1'b0;
      cyc($urandom_range(5));
    end

    set_ctl(0, 1, 1); cyc(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule